// File: doc/BRIEF.md
# Three-Stage Interrupt Priority Arbiter

This block gathers interrupt requests from a set of sources. It chooses at most one of them per arbitration round and hands it to the processor. Each source has three settings: an enable bit, a 4-bit priority level and a 2-bit group level. An event pulse on a source sets that source's pending flag. The flag stays set until the processor takes the request.

Arbitration runs through three registered stages. The first stage selects the best pending, enabled source. The second stage weighs that winner against a debug-service request and raises an injection request toward the processor. The third stage checks the candidate against the processor status: the global interrupt enable and the level of the running task. A request that passes the third stage produces a one-clock accept pulse, which carries the winning source index and its level. A debug request that wins produces its own one-clock pulse instead.

While one round is in flight, new requests wait. Vector fetch, context switching and the processor pipeline sit outside this block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: An event pulse on source i sets `pending[i]` on the next clock edge. The flag stays set through rejected rounds. It clears on the clock edge that follows the accept pulse for source i, unless a new event for i arrives in that same cycle.
- R2: The first stage considers only sources that are both pending and enabled. Among them it picks the one with the numerically highest priority level (4 bits, 0 to 15, packed so that source i uses `src_level[4i+3:4i]`). A disabled source never wins, whatever its level.
- R3: When priority levels are equal, the higher group level (2 bits, packed so that source i uses `src_group[2i+1:2i]`) wins. When group levels are also equal, the lower source index wins. The group level only matters when priority levels are equal.
- R4: If `dbg_req` is high when a round reaches the second stage, the debug request wins over any interrupt candidate. `dbg_take` then pulses for one clock, regardless of `psw_ien` and `psw_level`. No accept pulse occurs, and the interrupt stays pending for a later round.
- R5: The third stage accepts an interrupt candidate only when `psw_ien` is 1 and the candidate's level is strictly greater than `psw_level`. A level-0 source is therefore never accepted.
- R6: On an idle arbiter, when an event is sampled at clock edge 1, the accept pulse appears after clock edge 4 and not before. This is three clocks after the pending flag is set.
- R7: `take_pulse` is high for exactly one clock per accepted request. During that clock, `take_idx` and `take_level` hold the winner's index and level.
- R8: No new round starts while a round is in flight, nor in the cycle of an accept or debug pulse. A request that arrives during a round is considered in a later round.
- R9: While `rst_n` is low, all pending flags are cleared, event pulses are ignored, and no accept, debug or injection pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NUM_SRC | One-clock event pulse per source |
| src_enable | input | NUM_SRC | Per-source enable |
| src_level | input | NUM_SRC*4 | Packed per-source priority levels |
| src_group | input | NUM_SRC*2 | Packed per-source group levels |
| dbg_req | input | 1 | Debug-service request, held until `dbg_take` |
| psw_ien | input | 1 | Global interrupt enable from processor status |
| psw_level | input | 4 | Priority level of the running task |
| pending | output | NUM_SRC | Pending flags |
| inj_req | output | 1 | Injection request from stage two |
| take_pulse | output | 1 | Interrupt accept pulse |
| take_idx | output | clog2(NUM_SRC) | Index of the accepted source |
| take_level | output | 4 | Level of the accepted source |
| dbg_take | output | 1 | Debug request accepted |

## Verification
The case of interest is a debug request and an interrupt candidate reaching stage two in the same cycle. The bench provokes it by pulsing a source event and raising `dbg_req` one clock later, so that both meet at the second stage. The bench then checks four things: `dbg_take` pulses on the fourth edge, no accept pulse appears, the source's pending flag survives, and the interrupt is accepted four clocks after the debug pulse. A second clash has the same structure: a fresh event arrives while a round is in flight, and the bench checks that the event is deferred to the next round rather than merged into the current one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  localparam int GRP_W = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [GRP_W-1:0] grp_t;

  // candidate a strictly outranks candidate b: level first, then group
  function automatic logic outranks(input lvl_t la, input grp_t ga,
                                    input lvl_t lb, input grp_t gb);
    return (la > lb) || ((la == lb) && (ga > gb));
  endfunction

  // processor-side gate: global enable and strictly above task level
  function automatic logic clears_gate(input logic ien, input lvl_t cand,
                                       input lvl_t task_lvl);
    return ien && (cand > task_lvl);
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clr_hit;
    assign clr_hit = clr_en && (clr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= src_event[i] | (pend[i] & ~clr_hit);
    end
  end
endmodule

// File: rtl/irq_stage1_select.sv
module irq_stage1_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       elig,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic [NUM_SRC*GRP_W-1:0] grp_flat,
  input  logic                     launch,
  output logic                     s1_v,
  output logic                     s1_hit,
  output logic [IDX_W-1:0]         s1_idx,
  output lvl_t                     s1_lvl
);
  logic       found;
  logic [IDX_W-1:0] best_idx;
  lvl_t       best_lvl;
  grp_t       best_grp;

  // ascending scan with strict comparison keeps the lower index on full ties
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    best_grp = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i]) begin
        if (!found || outranks(lvl_flat[i*LVL_W +: LVL_W], grp_flat[i*GRP_W +: GRP_W],
                               best_lvl, best_grp)) begin
          found    = 1'b1;
          best_idx = IDX_W'(i);
          best_lvl = lvl_flat[i*LVL_W +: LVL_W];
          best_grp = grp_flat[i*GRP_W +: GRP_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_hit <= 1'b0;
      s1_idx <= '0;
      s1_lvl <= '0;
    end else begin
      s1_v <= launch;
      if (launch) begin
        s1_hit <= found;
        s1_idx <= best_idx;
        s1_lvl <= best_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_stage2_inject.sv
module irq_stage2_inject
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_v,
  input  logic             s1_hit,
  input  logic [IDX_W-1:0] s1_idx,
  input  lvl_t             s1_lvl,
  input  logic             dbg_req,
  output logic             s2_v,
  output logic             s2_dbg,
  output logic             s2_hit,
  output logic [IDX_W-1:0] s2_idx,
  output lvl_t             s2_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_dbg <= 1'b0;
      s2_hit <= 1'b0;
      s2_idx <= '0;
      s2_lvl <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        // debug service always displaces the interrupt candidate
        s2_dbg <= dbg_req;
        s2_hit <= s1_hit && !dbg_req;
        s2_idx <= s1_idx;
        s2_lvl <= s1_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_stage3_gate.sv
module irq_stage3_gate
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_v,
  input  logic             s2_dbg,
  input  logic             s2_hit,
  input  logic [IDX_W-1:0] s2_idx,
  input  lvl_t             s2_lvl,
  input  logic             psw_ien,
  input  lvl_t             psw_level,
  output logic             take_q,
  output logic [IDX_W-1:0] take_idx_q,
  output lvl_t             take_lvl_q,
  output logic             dbg_take_q
);
  logic irq_ok;
  assign irq_ok = s2_v && !s2_dbg && s2_hit && clears_gate(psw_ien, s2_lvl, psw_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q     <= 1'b0;
      dbg_take_q <= 1'b0;
      take_idx_q <= '0;
      take_lvl_q <= '0;
    end else begin
      take_q     <= irq_ok;
      dbg_take_q <= s2_v && s2_dbg;
      if (irq_ok) begin
        take_idx_q <= s2_idx;
        take_lvl_q <= s2_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_event,
  input  logic [NUM_SRC-1:0]           src_enable,
  input  logic [NUM_SRC*LVL_W-1:0]     src_level,
  input  logic [NUM_SRC*GRP_W-1:0]     src_group,
  input  logic                         dbg_req,
  input  logic                         psw_ien,
  input  logic [LVL_W-1:0]             psw_level,
  output logic [NUM_SRC-1:0]           pending,
  output logic                         inj_req,
  output logic                         take_pulse,
  output logic [$clog2(NUM_SRC)-1:0]   take_idx,
  output logic [LVL_W-1:0]             take_level,
  output logic                         dbg_take
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] elig;
  logic               any_elig;
  logic               arb_busy;
  logic               launch;

  logic             s1_v, s1_hit;
  logic [IDX_W-1:0] s1_idx;
  lvl_t             s1_lvl;
  logic             s2_dbg, s2_hit;
  logic [IDX_W-1:0] s2_idx;
  lvl_t             s2_lvl;

  assign elig     = pending & src_enable;
  assign any_elig = |elig;
  // a round holds the pipeline until its pulse and the flag clear are done
  assign arb_busy = s1_v | inj_req | take_pulse | dbg_take;
  assign launch   = !arb_busy && (any_elig || dbg_req);

  irq_pending_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_event (src_event),
    .clr_en    (take_pulse),
    .clr_idx   (take_idx),
    .pend      (pending)
  );

  irq_stage1_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .lvl_flat (src_level),
    .grp_flat (src_group),
    .launch   (launch),
    .s1_v     (s1_v),
    .s1_hit   (s1_hit),
    .s1_idx   (s1_idx),
    .s1_lvl   (s1_lvl)
  );

  irq_stage2_inject #(.IDX_W(IDX_W)) u_s2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_v    (s1_v),
    .s1_hit  (s1_hit),
    .s1_idx  (s1_idx),
    .s1_lvl  (s1_lvl),
    .dbg_req (dbg_req),
    .s2_v    (inj_req),
    .s2_dbg  (s2_dbg),
    .s2_hit  (s2_hit),
    .s2_idx  (s2_idx),
    .s2_lvl  (s2_lvl)
  );

  irq_stage3_gate #(.IDX_W(IDX_W)) u_s3 (
    .clk        (clk),
    .rst_n      (rst_n),
    .s2_v       (inj_req),
    .s2_dbg     (s2_dbg),
    .s2_hit     (s2_hit),
    .s2_idx     (s2_idx),
    .s2_lvl     (s2_lvl),
    .psw_ien    (psw_ien),
    .psw_level  (psw_level),
    .take_q     (take_pulse),
    .take_idx_q (take_idx),
    .take_lvl_q (take_level),
    .dbg_take_q (dbg_take)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_event,
  input logic [NUM_SRC-1:0] pending,
  input logic               psw_ien,
  input lvl_t               psw_level,
  input logic               inj_req,
  input logic               launch,
  input logic               take_pulse,
  input logic [IDX_W-1:0]   take_idx,
  input lvl_t               take_level,
  input logic               dbg_take
);
  assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> !take_pulse);

  assert_flag_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && !src_event[take_idx]) |=> !pending[$past(take_idx)]);

  assert_gate_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> ($past(psw_ien) && (take_level > $past(psw_level))));

  assert_level_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> (take_level != '0));

  assert_after_inject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse || dbg_take) |-> $past(inj_req));

  assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_pulse && dbg_take));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse || dbg_take) |-> !launch);
endmodule

bind irq_prio_arbiter irq_arb_checker #(.NUM_SRC(NUM_SRC), .IDX_W($clog2(NUM_SRC))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_event  (src_event),
  .pending    (pending),
  .psw_ien    (psw_ien),
  .psw_level  (psw_level),
  .inj_req    (inj_req),
  .launch     (launch),
  .take_pulse (take_pulse),
  .take_idx   (take_idx),
  .take_level (take_level),
  .dbg_take   (dbg_take)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_event = '0;
  logic [N-1:0] src_enable = '0;
  logic [N*4-1:0] src_level = '0;
  logic [N*2-1:0] src_group = '0;
  logic         dbg_req = 1'b0;
  logic         psw_ien = 1'b0;
  logic [3:0]   psw_level = '0;
  logic [N-1:0] pending;
  logic         inj_req, take_pulse, dbg_take;
  logic [2:0]   take_idx;
  logic [3:0]   take_level;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N)) u_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .src_enable(src_enable),
    .src_level(src_level), .src_group(src_group), .dbg_req(dbg_req),
    .psw_ien(psw_ien), .psw_level(psw_level), .pending(pending),
    .inj_req(inj_req), .take_pulse(take_pulse), .take_idx(take_idx),
    .take_level(take_level), .dbg_take(dbg_take)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [31:0] lv;
    logic [15:0] gp;
    logic [7:0]  ev;
    logic        ien;
    logic [3:0]  psw;
    logic        exp_take;
    logic [2:0]  exp_idx;
    logic [3:0]  exp_lvl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 32'h0000_5000, 16'h0000, 8'h08, 1'b1, 4'd0, 1'b1, 3'd3, 4'd5},  // R2 single
    '{8'hFF, 32'h0900_0070, 16'h0000, 8'h42, 1'b1, 4'd0, 1'b1, 3'd6, 4'd9},  // R2 highest level
    '{8'hFF, 32'h0070_0700, 16'h0C10, 8'h24, 1'b1, 4'd0, 1'b1, 3'd5, 4'd7},  // R3 group breaks tie
    '{8'hFF, 32'h0070_0700, 16'h0000, 8'h24, 1'b1, 4'd0, 1'b1, 3'd2, 4'd7},  // R3 lower index
    '{8'hFF, 32'h0000_5000, 16'h0000, 8'h08, 1'b0, 4'd0, 1'b0, 3'd0, 4'd0},  // R5 ien off
    '{8'hFF, 32'h0900_0000, 16'h0000, 8'h40, 1'b1, 4'd9, 1'b0, 3'd0, 4'd0},  // R5 equal to task
    '{8'hFF, 32'h0900_0000, 16'h0000, 8'h40, 1'b1, 4'd8, 1'b1, 3'd6, 4'd9},  // R5 one above task
    '{8'hFF, 32'h0000_0000, 16'h0000, 8'h01, 1'b1, 4'd0, 1'b0, 3'd0, 4'd0},  // R5 level zero
    '{8'hBF, 32'h0F00_0030, 16'h0000, 8'h42, 1'b1, 4'd0, 1'b1, 3'd1, 4'd3},  // R2 disabled ignored
    '{8'hFF, 32'h4000_0004, 16'h4000, 8'h81, 1'b1, 4'd0, 1'b1, 3'd7, 4'd4},  // R3 group over index
    '{8'hFF, 32'h0005_0060, 16'h0300, 8'h12, 1'b1, 4'd0, 1'b1, 3'd1, 4'd6}   // R3 level over group
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_event = '0;
    dbg_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // event sampled on the next rising edge; returns at the following falling edge
  task automatic pulse_event(input logic [N-1:0] m);
    src_event = m;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R9: reset holds everything quiet, events ignored
    src_enable = '1;
    src_level = 32'h1111_1111;
    psw_ien = 1'b1;
    src_event = '1;
    repeat (3) @(negedge clk);
    chk("R9 pending in reset", int'(pending), 0);
    chk("R9 take in reset", int'(take_pulse), 0);
    chk("R9 dbg in reset", int'(dbg_take), 0);
    chk("R9 inj in reset", int'(inj_req), 0);
    src_event = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pending after reset", int'(pending), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      do_reset();
      src_enable = VECS[v].en;
      src_level  = VECS[v].lv;
      src_group  = VECS[v].gp;
      psw_ien    = VECS[v].ien;
      psw_level  = VECS[v].psw;
      pulse_event(VECS[v].ev);
      chk("R1 pending set", int'(pending), int'(VECS[v].ev));
      repeat (2) @(negedge clk);
      chk("R6 no early accept", int'(take_pulse), 0);
      @(negedge clk);
      chk("R2/R3/R5 accept", int'(take_pulse), int'(VECS[v].exp_take));
      if (VECS[v].exp_take) begin
        chk("R7 index", int'(take_idx), int'(VECS[v].exp_idx));
        chk("R7 level", int'(take_level), int'(VECS[v].exp_lvl));
        @(negedge clk);
        chk("R7 single pulse", int'(take_pulse), 0);
        chk("R1 flag cleared", int'(pending[VECS[v].exp_idx]), 0);
      end else begin
        @(negedge clk);
        chk("R1 rejected stays pending", int'(pending), int'(VECS[v].ev));
      end
    end

    // R4: debug and interrupt meet at stage two
    do_reset();
    src_enable = '1;
    src_level = 32'h0000_0600;
    src_group = '0;
    psw_ien = 1'b1;
    psw_level = 4'd0;
    pulse_event(8'h04);
    dbg_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 dbg wins", int'(dbg_take), 1);
    chk("R4 no irq accept", int'(take_pulse), 0);
    chk("R4 irq still pending", int'(pending[2]), 1);
    dbg_req = 1'b0;
    @(negedge clk);
    chk("R4 dbg single pulse", int'(dbg_take), 0);
    repeat (3) @(negedge clk);
    chk("R8 irq after dbg", int'(take_pulse), 1);
    chk("R4 irq idx", int'(take_idx), 2);

    // R4: debug bypasses the processor gate
    do_reset();
    psw_ien = 1'b0;
    dbg_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 dbg with ien off", int'(dbg_take), 1);
    dbg_req = 1'b0;

    // R8: a request arriving mid-round waits for the next round
    do_reset();
    psw_ien = 1'b1;
    src_level = 32'h0000_0930;
    pulse_event(8'h02);
    pulse_event(8'h04);
    repeat (2) @(negedge clk);
    chk("R8 first round winner", int'(take_idx), 1);
    chk("R8 first round pulse", int'(take_pulse), 1);
    @(negedge clk);
    chk("R1 first cleared", int'(pending[1]), 0);
    chk("R8 late still pending", int'(pending[2]), 1);
    repeat (2) @(negedge clk);
    chk("R8 no early relaunch", int'(take_pulse), 0);
    @(negedge clk);
    chk("R8 second round pulse", int'(take_pulse), 1);
    chk("R8 second round idx", int'(take_idx), 2);

    // R1/R5: rejected request taken once the gate opens
    do_reset();
    psw_ien = 1'b0;
    src_level = 32'h0600_0000;
    pulse_event(8'h40);
    repeat (6) @(negedge clk);
    chk("R5 held while ien off", int'(take_pulse), 0);
    chk("R1 held pending", int'(pending[6]), 1);
    psw_ien = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (take_pulse && !seen) begin
          seen = 1'b1;
          chk("R5 late accept idx", int'(take_idx), 6);
        end
      end
      chk("R5 late accept seen", int'(seen), 1);
    end

    finish_run();
  end
endmodule